// File: doc/BRIEF.md
# Multimode Pulse Counter with Compare

This block is a single counting channel for incremental encoders and pulse sources. Two pulse inputs, A and B, pass through a synchronizer. A decoder turns their edges into up or down steps according to one of six input modes. The steps update a 32-bit present value that wraps in both directions.

A host programs the block through a simple register port: a write strobe with address and data, and a combinational read-back. Through it the host starts and stops counting, picks the mode, sets a preset value and a compare point, and issues commands. Two external pins act on the count. One loads the preset into the present value. The other copies the present value into a latch register that the host can read.

The present value is compared with the compare point on every cycle. When they become equal, the block sets a sticky coincidence flag and raises a one-cycle interrupt request. The flag drives the coincidence output only while the host has enabled that output.

Top module: `pcnt_top`

## Requirements
- R1: After reset the present value, latch register, compare point, preset value and coincidence flag read 0, both outputs are low, and no interrupt is issued although the present value equals the compare point.
- R2: Single-phase modes (mode code 0 = rising edges of A, code 1 = both edges of A) count one step per selected edge. The step is up while B is low and down while B is high.
- R3: In mode code 2, a rising edge on A counts up and a rising edge on B counts down. If both rise in the same cycle, the count is unchanged.
- R4: Two-phase modes follow the Gray order 00→10→11→01→00 of (A,B) as up and the reverse as down. Code 3 counts only A edges seen while B is low (A rising up, A falling down). Code 4 counts every A edge. Code 5 counts every edge of A and B.
- R5: Steps change the present value only while the count-enable bit (bit 0 of the control register) is 1. With it 0, the value holds.
- R6: A rising edge on the preset pin, or a write of 1 to bit 0 of the command register, loads the preset value. If this happens in the same cycle as a count step, the load wins.
- R7: A rising edge on the latch pin copies the present value into the latch register without changing the present value. The latch register then holds until the next latch edge.
- R8: The present value wraps modulo 2^32: 0 minus one step gives 0xFFFFFFFF, and 0xFFFFFFFF plus one step gives 0.
- R9: The coincidence flag (status bit 0) sets on the first cycle of equality and stays set until the host writes 1 to command bit 1. The coincidence output is the flag gated by the output-enable bit (control bit 4).
- R10: The interrupt request is high for exactly one cycle, on the first cycle in which the present value equals the compare point.
- R11: Register offsets: 0 control (bit 0 enable, bits 3:1 mode, bit 4 output enable), 1 command (write only), 2 preset value, 3 compare point, 4 present value, 5 latch register, 6 status (bit 0 flag, bits 1 to 4 the synchronized A, B, preset pin and latch pin).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pulse_a | input | 1 | Pulse input A (asynchronous) |
| pulse_b | input | 1 | Pulse input B (asynchronous) |
| preset_pin | input | 1 | External preset control, rising edge acts |
| latch_pin | input | 1 | External latch control, rising edge acts |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 3 | Host register offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for host_addr |
| coin_out | output | 1 | Coincidence output |
| irq | output | 1 | One-cycle interrupt request on a new match |

## Verification
The hardest situation to reach from the ports is an external preset edge and a count edge resolving in the same cycle. The stimulus creates it by raising the preset pin and pulse A on the same falling clock edge. Both then pass through identical synchronizer depths and reach the counter together, and the bench expects the preset value with no added step. Two other cases need care to set up. One is a match that is left and then re-entered while the output is disabled. The other is a stop with pulses still arriving. For both, the bench checks the flag, the interrupt count and the held value at the ports.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;

    typedef enum logic [2:0] {
        MD_SP1 = 3'd0,
        MD_SP2 = 3'd1,
        MD_DIR = 3'd2,
        MD_QX1 = 3'd3,
        MD_QX2 = 3'd4,
        MD_QX4 = 3'd5
    } pcnt_mode_e;

    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DN   = 2'd2
    } pcnt_step_e;

    typedef struct packed {
        logic a;
        logic b;
        logic pre;
        logic lat;
    } pcnt_pins_t;

    localparam int PINS_W = $bits(pcnt_pins_t);

    localparam logic [2:0] ADDR_CTRL   = 3'd0;
    localparam logic [2:0] ADDR_CMD    = 3'd1;
    localparam logic [2:0] ADDR_PRESET = 3'd2;
    localparam logic [2:0] ADDR_CMP    = 3'd3;
    localparam logic [2:0] ADDR_PV     = 3'd4;
    localparam logic [2:0] ADDR_LATCH  = 3'd5;
    localparam logic [2:0] ADDR_STATUS = 3'd6;

    function automatic pcnt_step_e pcnt_decode_step(
        input pcnt_mode_e m,
        input logic a, input logic b,
        input logic pa, input logic pb
    );
        logic a_rise, b_rise, a_chg, b_chg;
        pcnt_step_e s;
        a_rise = a & ~pa;
        b_rise = b & ~pb;
        a_chg  = a ^ pa;
        b_chg  = b ^ pb;
        s      = STEP_NONE;
        case (m)
            MD_SP1: if (a_rise) s = b ? STEP_DN : STEP_UP;
            MD_SP2: if (a_chg)  s = b ? STEP_DN : STEP_UP;
            MD_DIR: begin
                if (a_rise && !b_rise)      s = STEP_UP;
                else if (b_rise && !a_rise) s = STEP_DN;
            end
            MD_QX1: if (a_chg && !b_chg && !b) s = a_rise ? STEP_UP : STEP_DN;
            MD_QX2: if (a_chg && !b_chg) s = (a != b) ? STEP_UP : STEP_DN;
            MD_QX4: begin
                if (a_chg && !b_chg)      s = (a != b) ? STEP_UP : STEP_DN;
                else if (b_chg && !a_chg) s = (a == b) ? STEP_UP : STEP_DN;
            end
            default: s = STEP_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/pcnt_sync.sv
module pcnt_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= '0;
                else     stg[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= '0;
                else     stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/pcnt_decode.sv
module pcnt_decode
    import pcnt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  pcnt_pins_t cur,
    input  pcnt_mode_e mode,
    output pcnt_step_e step,
    output logic       pre_rise,
    output logic       lat_rise
);
    pcnt_pins_t prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= cur;
    end

    always_comb begin
        step     = pcnt_decode_step(mode, cur.a, cur.b, prev.a, prev.b);
        pre_rise = cur.pre & ~prev.pre;
        lat_rise = cur.lat & ~prev.lat;
    end
endmodule

// File: rtl/pcnt_core.sv
module pcnt_core
    import pcnt_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cnt_en,
    input  pcnt_step_e    step,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          latch_evt,
    output logic [CW-1:0] pv,
    output logic [CW-1:0] latch_q
);
    localparam logic [CW-1:0] ONE = CW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            pv      <= '0;
            latch_q <= '0;
        end else begin
            if (latch_evt) latch_q <= pv;
            if (load)                              pv <= load_val;
            else if (cnt_en && step == STEP_UP)    pv <= pv + ONE;
            else if (cnt_en && step == STEP_DN)    pv <= pv - ONE;
        end
    end
endmodule

// File: rtl/pcnt_compare.sv
module pcnt_compare #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] pv,
    input  logic [CW-1:0] cmp,
    input  logic          clr,
    input  logic          out_en,
    output logic          flag,
    output logic          coin_out,
    output logic          irq
);
    logic eq, eq_d;

    assign eq  = (pv == cmp);
    assign irq = eq & ~eq_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            eq_d <= 1'b1;
            flag <= 1'b0;
        end else begin
            eq_d <= eq;
            if (clr)      flag <= 1'b0;
            else if (irq) flag <= 1'b1;
        end
    end

    assign coin_out = flag & out_en;
endmodule

// File: rtl/pcnt_top.sv
module pcnt_top
    import pcnt_pkg::*;
#(
    parameter int CW          = 32,
    parameter int AW          = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pulse_a,
    input  logic          pulse_b,
    input  logic          preset_pin,
    input  logic          latch_pin,
    input  logic          host_wr,
    input  logic [AW-1:0] host_addr,
    input  logic [CW-1:0] host_wdata,
    output logic [CW-1:0] host_rdata,
    output logic          coin_out,
    output logic          irq
);
    pcnt_pins_t raw_pins, syn_pins;
    logic [PINS_W-1:0] syn_vec;

    logic          cnt_en_q, coin_en_q;
    pcnt_mode_e    mode_q;
    logic [CW-1:0] preset_q, cmp_q;
    logic [CW-1:0] pv_w, latch_w;
    pcnt_step_e    step_w;
    logic          pre_rise, lat_rise, load_w, clr_w, cmd_wr, flag_w;

    assign raw_pins = '{a: pulse_a, b: pulse_b, pre: preset_pin, lat: latch_pin};

    pcnt_sync #(.W(PINS_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(raw_pins), .q(syn_vec)
    );
    assign syn_pins = pcnt_pins_t'(syn_vec);

    pcnt_decode u_dec (
        .clk(clk), .rst(rst), .cur(syn_pins), .mode(mode_q),
        .step(step_w), .pre_rise(pre_rise), .lat_rise(lat_rise)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_en_q  <= 1'b0;
            coin_en_q <= 1'b0;
            mode_q    <= MD_SP1;
            preset_q  <= '0;
            cmp_q     <= '0;
        end else if (host_wr) begin
            case (AW'(host_addr))
                AW'(ADDR_CTRL): begin
                    cnt_en_q  <= host_wdata[0];
                    mode_q    <= pcnt_mode_e'(host_wdata[3:1]);
                    coin_en_q <= host_wdata[4];
                end
                AW'(ADDR_PRESET): preset_q <= host_wdata;
                AW'(ADDR_CMP):    cmp_q    <= host_wdata;
                default: ;
            endcase
        end
    end

    assign cmd_wr = host_wr && (host_addr == AW'(ADDR_CMD));
    assign load_w = pre_rise | (cmd_wr & host_wdata[0]);
    assign clr_w  = cmd_wr & host_wdata[1];

    pcnt_core #(.CW(CW)) u_core (
        .clk(clk), .rst(rst), .cnt_en(cnt_en_q), .step(step_w),
        .load(load_w), .load_val(preset_q), .latch_evt(lat_rise),
        .pv(pv_w), .latch_q(latch_w)
    );

    pcnt_compare #(.CW(CW)) u_cmp (
        .clk(clk), .rst(rst), .pv(pv_w), .cmp(cmp_q), .clr(clr_w),
        .out_en(coin_en_q), .flag(flag_w), .coin_out(coin_out), .irq(irq)
    );

    always_comb begin
        host_rdata = '0;
        case (AW'(host_addr))
            AW'(ADDR_CTRL): begin
                host_rdata[0]   = cnt_en_q;
                host_rdata[3:1] = mode_q;
                host_rdata[4]   = coin_en_q;
            end
            AW'(ADDR_PRESET): host_rdata = preset_q;
            AW'(ADDR_CMP):    host_rdata = cmp_q;
            AW'(ADDR_PV):     host_rdata = pv_w;
            AW'(ADDR_LATCH):  host_rdata = latch_w;
            AW'(ADDR_STATUS): begin
                host_rdata[0] = flag_w;
                host_rdata[1] = syn_pins.a;
                host_rdata[2] = syn_pins.b;
                host_rdata[3] = syn_pins.pre;
                host_rdata[4] = syn_pins.lat;
            end
            default: host_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pcnt_chk.sv
module pcnt_chk #(
    parameter int CW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          cnt_en,
    input logic          load,
    input logic [CW-1:0] load_val,
    input logic          latch_evt,
    input logic [CW-1:0] pv,
    input logic [CW-1:0] latch_q,
    input logic          irq,
    input logic          clr,
    input logic          flag
);
    p_freeze_r5: assert property (@(posedge clk) disable iff (rst)
        (!cnt_en && !load) |=> $stable(pv));

    p_load_r6: assert property (@(posedge clk) disable iff (rst)
        load |=> (pv == $past(load_val)));

    p_latch_r7: assert property (@(posedge clk) disable iff (rst)
        latch_evt |=> (latch_q == $past(pv)));

    p_unit_step_r8: assert property (@(posedge clk) disable iff (rst)
        !load |=> (pv == $past(pv) || pv == $past(pv) + 1'b1 || pv == $past(pv) - 1'b1));

    p_irq_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    p_flag_set_r9: assert property (@(posedge clk) disable iff (rst)
        (irq && !clr) |=> flag);

    p_flag_clear_r9: assert property (@(posedge clk) disable iff (rst)
        clr |=> !flag);
endmodule

bind pcnt_top pcnt_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst(rst), .cnt_en(cnt_en_q), .load(load_w),
    .load_val(preset_q), .latch_evt(lat_rise), .pv(pv_w),
    .latch_q(latch_w), .irq(irq), .clr(clr_w), .flag(flag_w)
);

// File: tb/pcnt_top_tb_top.sv
module pcnt_top_tb_top;
    localparam int CW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pulse_a = 1'b0, pulse_b = 1'b0, preset_pin = 1'b0, latch_pin = 1'b0;
    logic          host_wr = 1'b0;
    logic [2:0]    host_addr = 3'd0;
    logic [CW-1:0] host_wdata = '0;
    logic [CW-1:0] host_rdata;
    logic          coin_out, irq;

    int n_checks = 0;
    int n_errors = 0;
    int irq_cnt  = 0;
    bit done     = 1'b0;

    typedef struct {
        int          kind;   // 0 register, 1 coin_out, 2 irq count
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #10ns clk = ~clk;

    pcnt_top dut_i (
        .clk(clk), .rst(rst), .pulse_a(pulse_a), .pulse_b(pulse_b),
        .preset_pin(preset_pin), .latch_pin(latch_pin), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .coin_out(coin_out), .irq(irq)
    );

    always @(negedge clk) if (!rst && irq) irq_cnt++;

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #5ns;
            while (sb_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sb_q.pop_front();
                case (it.kind)
                    0:       act = host_rdata;
                    1:       act = {31'd0, coin_out};
                    default: act = irq_cnt;
                endcase
                n_checks++;
                if (act !== it.exp) begin
                    n_errors++;
                    $display("FAIL %s: actual=0x%08h expected=0x%08h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0; host_wdata = '0;
        wait_cyc(3);
    endtask

    task automatic expect_item(input int kind, input logic [2:0] a,
                               input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        host_addr = a;
        it.kind = kind; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        wait_cyc(2);
    endtask

    task automatic set_ab(input logic a, input logic b);
        @(negedge clk);
        pulse_a = a; pulse_b = b;
        wait_cyc(4);
    endtask

    task automatic pulse_a_n(input int n);
        for (int i = 0; i < n; i++) begin
            set_ab(1'b1, pulse_b);
            set_ab(1'b0, pulse_b);
        end
    endtask

    task automatic fwd_cycle;
        set_ab(1, 0); set_ab(1, 1); set_ab(0, 1); set_ab(0, 0);
    endtask

    task automatic rev_cycle;
        set_ab(0, 1); set_ab(1, 1); set_ab(1, 0); set_ab(0, 0);
    endtask

    // watchdog
    initial begin
        #(20ns * 100000);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(3);
        // R1 reset state (pv == cmp == 0 yet no interrupt)
        expect_item(0, 3'd4, 32'd0, "R1 present value");
        expect_item(0, 3'd5, 32'd0, "R1 latch");
        expect_item(0, 3'd6, 32'd0, "R1 status");
        expect_item(1, 3'd0, 32'd0, "R1 coin_out");
        expect_item(2, 3'd0, 32'd0, "R1 irq count");

        wr(3'd3, 32'd1000);
        // R11 control readback, R2 single-phase x1
        wr(3'd0, 32'd1);
        expect_item(0, 3'd0, 32'd1, "R11 control readback");
        pulse_a_n(3);
        expect_item(0, 3'd4, 32'd3, "R2 x1 up");
        set_ab(0, 1);
        pulse_a_n(2);
        expect_item(0, 3'd4, 32'd1, "R2 x1 down");
        set_ab(0, 0);

        // R2 single-phase x2
        wr(3'd0, 32'd3);
        wr(3'd1, 32'd1);
        expect_item(0, 3'd4, 32'd0, "R6 command preset");
        pulse_a_n(2);
        expect_item(0, 3'd4, 32'd4, "R2 x2 up");

        // R3 CW/CCW
        wr(3'd0, 32'd5);
        wr(3'd1, 32'd1);
        pulse_a_n(3);
        expect_item(0, 3'd4, 32'd3, "R3 A up");
        set_ab(0, 1); set_ab(0, 0);
        expect_item(0, 3'd4, 32'd2, "R3 B down");
        set_ab(1, 1); set_ab(0, 0);
        expect_item(0, 3'd4, 32'd2, "R3 cancel");

        // R4 two-phase x4
        wr(3'd0, 32'd11);
        wr(3'd1, 32'd1);
        fwd_cycle();
        expect_item(0, 3'd4, 32'd4, "R4 x4 forward");
        set_ab(0, 1); set_ab(1, 1);
        expect_item(0, 3'd4, 32'd2, "R4 x4 reverse half");
        set_ab(1, 0); set_ab(0, 0);
        expect_item(0, 3'd4, 32'd0, "R4 x4 reverse full");

        // R4 two-phase x2
        wr(3'd0, 32'd9);
        wr(3'd1, 32'd1);
        fwd_cycle();
        expect_item(0, 3'd4, 32'd2, "R4 x2 forward");

        // R4 two-phase x1
        wr(3'd0, 32'd7);
        wr(3'd1, 32'd1);
        fwd_cycle();
        expect_item(0, 3'd4, 32'd1, "R4 x1 forward");
        rev_cycle();
        expect_item(0, 3'd4, 32'd0, "R4 x1 reverse");

        // R5 stopped
        wr(3'd0, 32'd0);
        pulse_a_n(2);
        expect_item(0, 3'd4, 32'd0, "R5 stop holds");

        // R8 wrap
        wr(3'd0, 32'd1);
        set_ab(0, 1);
        pulse_a_n(1);
        expect_item(0, 3'd4, 32'hFFFF_FFFF, "R8 wrap down");
        set_ab(0, 0);
        pulse_a_n(1);
        expect_item(0, 3'd4, 32'd0, "R8 wrap up");

        // R6 preset pin
        wr(3'd2, 32'd100);
        @(negedge clk); preset_pin = 1'b1; wait_cyc(4);
        @(negedge clk); preset_pin = 1'b0; wait_cyc(4);
        expect_item(0, 3'd4, 32'd100, "R6 pin preset");

        // R6 preset beats count in same cycle
        wr(3'd2, 32'd123);
        @(negedge clk); preset_pin = 1'b1; pulse_a = 1'b1; wait_cyc(4);
        @(negedge clk); preset_pin = 1'b0; pulse_a = 1'b0; wait_cyc(4);
        expect_item(0, 3'd4, 32'd123, "R6 preset wins");

        // R7 latch
        @(negedge clk); latch_pin = 1'b1; wait_cyc(4);
        @(negedge clk); latch_pin = 1'b0; wait_cyc(4);
        expect_item(0, 3'd5, 32'd123, "R7 latch captured");
        expect_item(0, 3'd4, 32'd123, "R7 count undisturbed");
        pulse_a_n(1);
        expect_item(0, 3'd4, 32'd124, "R7 counts after latch");
        expect_item(0, 3'd5, 32'd123, "R7 latch held");

        // R9 / R10 coincidence and interrupt
        wr(3'd0, 32'd17);
        wr(3'd3, 32'd125);
        pulse_a_n(1);
        expect_item(1, 3'd0, 32'd1, "R9 coin on match");
        expect_item(2, 3'd0, 32'd1, "R10 one interrupt");
        pulse_a_n(1);
        expect_item(1, 3'd0, 32'd1, "R9 coin sticky");
        expect_item(2, 3'd0, 32'd1, "R10 no interrupt off match");
        wr(3'd1, 32'd2);
        expect_item(1, 3'd0, 32'd0, "R9 coin cleared");
        expect_item(0, 3'd6, 32'd0, "R9 flag cleared");
        wr(3'd0, 32'd1);
        set_ab(0, 1);
        pulse_a_n(1);
        set_ab(0, 0);
        expect_item(0, 3'd4, 32'd125, "R9 back on match");
        expect_item(1, 3'd0, 32'd0, "R9 output gated");
        expect_item(0, 3'd6, 32'd1, "R9 flag set while gated");
        expect_item(2, 3'd0, 32'd2, "R10 second interrupt");

        wait_cyc(4);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule